// File: doc/BRIEF.md
# Preloaded Timer Time Base

This block is the counting engine of a general-purpose timer. A programmable prescaler turns the system clock into count ticks, and a counter steps once per tick. The counter can count upward, downward, or up and then down in center-aligned fashion. Both the prescaler divisor and the reload limit are double-buffered. Software writes go into a holding register, and the working copy changes at an update event: a counter wrap or a software update strobe.

Software programs the block through plain level and strobe inputs. Other timer logic uses the outputs: the live count, the direction, a one-cycle tick strobe, a one-cycle update pulse and a sticky update flag. Update events can be blocked completely, so that no pulse is produced and no buffered value is loaded, while the counter still wraps. Update events caused by the software strobe can also be kept out of the flag, which stops a counter clear from looking like a period boundary.

Top module: `tbase_core`

## Requirements
- R1: After synchronous reset the count is 0, direction is up (`dir_down_o`=0), and `tick_o`, `upd_evt_o` and `upd_flag_o` are 0. The active prescale value is 0 and the active reload value is all ones.
- R2: The run input is registered once. With a prescale value of 0, the count first changes at the second rising edge at which `cfg_run` is sampled high, and `tick_o` is high in the cycle between those two edges.
- R3: With an active prescale value P, `tick_o` is high once every P+1 clock cycles. Between ticks the count holds unless a software update or a counter write occurs.
- R4: A prescale value that is written is not used until the next update event. A software update also clears the prescaler phase, so the first tick with a new value 0 comes in the cycle right after the event.
- R5: In up mode (`cfg_center`=0, `cfg_down`=0) the count runs 0 to the reload value and then returns to 0. In the cycle that shows 0, `upd_evt_o` is high and `upd_flag_o` becomes 1.
- R6: In down mode (`cfg_center`=0, `cfg_down`=1) the count runs from the reload value to 0, then reloads the reload value with an update event. In edge modes `dir_down_o` follows `cfg_down` one cycle later.
- R7: In center mode (`cfg_center`=1) the count rises to the reload value and then falls to 0. Leaving the top sets `dir_down_o` to 1 and leaving 0 sets it back to 0. Each turn gives an update event, so with reload N the sequence is 0..N, N-1..0, 1.
- R8: With `cfg_arr_buffered`=0 a reload write takes effect at the next edge. With `cfg_arr_buffered`=1 the written value becomes active only at an update event.
- R9: While `cfg_upd_block`=1 no `upd_evt_o` pulse occurs, the flag is not set and no buffered value is loaded. The counter still wraps, and the software strobe still clears the count.
- R10: The `sw_upd` strobe returns the count to 0 (or to the reload value in down mode) at the next edge, produces an update event and loads the buffered values.
- R11: When `cfg_sw_quiet`=1, an update caused by `sw_upd` still pulses `upd_evt_o` but leaves `upd_flag_o` unchanged.
- R12: `upd_flag_o` stays 1 until `flag_clr` is pulsed. If an update sets the flag in the same cycle as `flag_clr`, the flag ends up 1.
- R13: In center mode, a counter write of 0 sets the direction up and a write of the reload value sets it down, with no update event. A write of a value above the reload value leaves the direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_run | input | 1 | Counter run enable (level) |
| cfg_down | input | 1 | Count downward in edge modes |
| cfg_center | input | 1 | Center-aligned up/down counting |
| cfg_upd_block | input | 1 | Suppress update events |
| cfg_sw_quiet | input | 1 | Software updates leave the flag untouched |
| cfg_arr_buffered | input | 1 | Reload writes wait for an update event |
| psc_wr_en | input | 1 | Prescale write strobe |
| psc_wr_val | input | 16 | Prescale value (divisor minus one) |
| arr_wr_en | input | 1 | Reload write strobe |
| arr_wr_val | input | 16 | Reload value |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_val | input | 16 | Counter write value |
| sw_upd | input | 1 | Software update strobe |
| flag_clr | input | 1 | Clear the update flag |
| cnt_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting downward |
| tick_o | output | 1 | Counter advances at the next edge |
| upd_evt_o | output | 1 | One-cycle update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |

## Verification
A wrong prescaler phase or a wrong active prescale value changes the spacing between `tick_o` pulses, and this is visible within one period of P+1 cycles. A wrong active reload value or a wrong direction bit moves the wrap point, and the count shows the error at the next turn as an extra step or a missing `upd_evt_o`. A buffered value loaded at the wrong time, or not loaded at all, shows only after the next update event, so the tests always run through at least one event after each buffered write.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2
    } cnt_mode_e;

    typedef struct packed {
        logic fire;     // an update event is accepted this cycle
        logic flag_set; // the flag should be raised this cycle
    } upd_ctl_t;

    function automatic cnt_mode_e pick_mode(input logic center, input logic down);
        if (center)    return MODE_CENTER;
        else if (down) return MODE_DOWN;
        else           return MODE_UP;
    endfunction

    function automatic upd_ctl_t decide_update(input logic wrap, input logic sw,
                                               input logic block, input logic quiet);
        upd_ctl_t r;
        r.fire     = (wrap | sw) & ~block;
        r.flag_set = r.fire & ~(sw & quiet);
        return r;
    endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_en,
    input  logic [PSC_W-1:0] wr_val,
    input  logic             load,
    input  logic             restart,
    output logic             tick
);
    logic [PSC_W-1:0] held_q;
    logic [PSC_W-1:0] active_q;
    logic [PSC_W-1:0] phase_q;

    assign tick = run && (phase_q == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            active_q <= '0;
            phase_q  <= '0;
        end else begin
            if (wr_en)
                held_q <= wr_val;
            if (load)
                active_q <= wr_en ? wr_val : held_q;
            if (restart || tick)
                phase_q <= '0;
            else if (run)
                phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbase_reload.sv
module tbase_reload #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buffered,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             load,
    output logic [CNT_W-1:0] limit
);
    logic [CNT_W-1:0] held_q;
    logic [CNT_W-1:0] active_q;

    assign limit = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= RST_VAL;
            active_q <= RST_VAL;
        end else begin
            if (wr_en)
                held_q <= wr_val;
            if (wr_en && !buffered)
                active_q <= wr_val;
            else if (load)
                active_q <= wr_en ? wr_val : held_q;
        end
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode,
    input  logic             tick,
    input  logic             sw_restart,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             at_top;
    logic             at_bot;

    assign cnt      = cnt_q;
    assign dir_down = dir_q;
    assign at_top   = (cnt_q >= limit);
    assign at_bot   = (cnt_q == '0);

    always_comb begin
        unique case (mode)
            MODE_DOWN:   wrap = tick && at_bot;
            MODE_CENTER: wrap = tick && (dir_q ? at_bot : at_top);
            default:     wrap = tick && at_top;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            if (mode != MODE_CENTER)
                dir_q <= (mode == MODE_DOWN);

            if (sw_restart) begin
                cnt_q <= (mode == MODE_DOWN) ? limit : '0;
                if (mode == MODE_CENTER)
                    dir_q <= 1'b0;
            end else if (wr_en) begin
                cnt_q <= wr_val;
                if (mode == MODE_CENTER) begin
                    if (wr_val == '0)
                        dir_q <= 1'b0;
                    else if (wr_val == limit)
                        dir_q <= 1'b1;
                end
            end else if (tick) begin
                unique case (mode)
                    MODE_DOWN:
                        cnt_q <= at_bot ? limit : cnt_q - 1'b1;
                    MODE_CENTER: begin
                        if (!dir_q) begin
                            if (at_top) begin
                                cnt_q <= (limit == '0) ? '0 : limit - 1'b1;
                                dir_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end else begin
                            if (at_bot) begin
                                cnt_q <= (limit == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                                dir_q <= 1'b0;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    default:
                        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/tbase_core.sv
module tbase_core
    import tbase_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter int               PSC_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_run,
    input  logic             cfg_down,
    input  logic             cfg_center,
    input  logic             cfg_upd_block,
    input  logic             cfg_sw_quiet,
    input  logic             cfg_arr_buffered,
    input  logic             psc_wr_en,
    input  logic [PSC_W-1:0] psc_wr_val,
    input  logic             arr_wr_en,
    input  logic [CNT_W-1:0] arr_wr_val,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic             sw_upd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             tick_o,
    output logic             upd_evt_o,
    output logic             upd_flag_o
);
    logic             run_q;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] limit;
    cnt_mode_e        mode;
    upd_ctl_t         ctl;
    logic             evt_q;
    logic             flag_q;

    assign mode = pick_mode(cfg_center, cfg_down);
    assign ctl  = decide_update(wrap, sw_upd, cfg_upd_block, cfg_sw_quiet);

    tbase_prescaler #(.PSC_W(PSC_W)) psc_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .wr_en   (psc_wr_en),
        .wr_val  (psc_wr_val),
        .load    (ctl.fire),
        .restart (sw_upd),
        .tick    (tick)
    );

    tbase_reload #(.CNT_W(CNT_W), .RST_VAL(RELOAD_RST)) rld_i (
        .clk      (clk),
        .rst      (rst),
        .buffered (cfg_arr_buffered),
        .wr_en    (arr_wr_en),
        .wr_val   (arr_wr_val),
        .load     (ctl.fire),
        .limit    (limit)
    );

    tbase_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .tick       (tick),
        .sw_restart (sw_upd),
        .wr_en      (cnt_wr_en),
        .wr_val     (cnt_wr_val),
        .limit      (limit),
        .cnt        (cnt_o),
        .dir_down   (dir_down_o),
        .wrap       (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            evt_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            run_q <= cfg_run;
            evt_q <= ctl.fire;
            if (ctl.flag_set)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign tick_o     = tick;
    assign upd_evt_o  = evt_q;
    assign upd_flag_o = flag_q;
endmodule

// File: rtl/tbase_core_chk.sv
module tbase_core_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_down,
    input logic             cfg_center,
    input logic             cfg_upd_block,
    input logic             cfg_sw_quiet,
    input logic             cnt_wr_en,
    input logic             sw_upd,
    input logic [CNT_W-1:0] cnt_o,
    input logic             tick_o,
    input logic             upd_evt_o,
    input logic             upd_flag_o
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        seen && $past(!tick_o && !sw_upd && !cnt_wr_en) |-> cnt_o == $past(cnt_o));

    p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
        seen && $past(tick_o && !cfg_center && !cfg_down && !sw_upd && !cnt_wr_en)
        |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)) || (cnt_o == '0));

    p_down_step_r6: assert property (@(posedge clk) disable iff (rst)
        seen && $past(tick_o && !cfg_center && cfg_down && !sw_upd && !cnt_wr_en)
        |-> (cnt_o == CNT_W'($past(cnt_o) - 1'b1)) || ($past(cnt_o) == '0));

    p_block_r9: assert property (@(posedge clk) disable iff (rst)
        seen && $past(cfg_upd_block) |-> !upd_evt_o);

    p_evt_cause_r10: assert property (@(posedge clk) disable iff (rst)
        upd_evt_o |-> seen && $past(sw_upd || tick_o));

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        seen && $past(sw_upd && cfg_sw_quiet && !cfg_upd_block && !upd_flag_o)
        |-> upd_evt_o && !upd_flag_o);

    p_flag_src_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_flag_o) |-> upd_evt_o);
endmodule

bind tbase_core tbase_core_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_down      (cfg_down),
    .cfg_center    (cfg_center),
    .cfg_upd_block (cfg_upd_block),
    .cfg_sw_quiet  (cfg_sw_quiet),
    .cnt_wr_en     (cnt_wr_en),
    .sw_upd        (sw_upd),
    .cnt_o         (cnt_o),
    .tick_o        (tick_o),
    .upd_evt_o     (upd_evt_o),
    .upd_flag_o    (upd_flag_o)
);

// File: tb/tbase_core_tb_top.sv
module tbase_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_run = 0, cfg_down = 0, cfg_center = 0;
    logic        cfg_upd_block = 0, cfg_sw_quiet = 0, cfg_arr_buffered = 0;
    logic        psc_wr_en = 0, arr_wr_en = 0, cnt_wr_en = 0;
    logic [15:0] psc_wr_val = 0, arr_wr_val = 0, cnt_wr_val = 0;
    logic        sw_upd = 0, flag_clr = 0;
    logic [15:0] cnt_o;
    logic        dir_down_o, tick_o, upd_evt_o, upd_flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    tbase_core dut_i (
        .clk(clk), .rst(rst), .cfg_run(cfg_run), .cfg_down(cfg_down),
        .cfg_center(cfg_center), .cfg_upd_block(cfg_upd_block),
        .cfg_sw_quiet(cfg_sw_quiet), .cfg_arr_buffered(cfg_arr_buffered),
        .psc_wr_en(psc_wr_en), .psc_wr_val(psc_wr_val),
        .arr_wr_en(arr_wr_en), .arr_wr_val(arr_wr_val),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
        .sw_upd(sw_upd), .flag_clr(flag_clr),
        .cnt_o(cnt_o), .dir_down_o(dir_down_o), .tick_o(tick_o),
        .upd_evt_o(upd_evt_o), .upd_flag_o(upd_flag_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        cfg_run = 0; cfg_down = 0; cfg_center = 0; cfg_upd_block = 0;
        cfg_sw_quiet = 0; cfg_arr_buffered = 0;
        psc_wr_en = 0; arr_wr_en = 0; cnt_wr_en = 0; sw_upd = 0; flag_clr = 0;
        psc_wr_val = 0; arr_wr_val = 0; cnt_wr_val = 0;
        rst = 1;
        cyc(2);
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        cyc(1);
        chk("R1", "cnt", cnt_o, 0);
        chk("R1", "dir", dir_down_o, 0);
        chk("R1", "tick", tick_o, 0);
        chk("R1", "evt", upd_evt_o, 0);
        chk("R1", "flag", upd_flag_o, 0);
    endtask

    task automatic t_up_wrap();
        do_reset();
        arr_wr_en = 1; arr_wr_val = 4; cfg_run = 1;
        cyc(1); arr_wr_en = 0;
        chk("R2", "cnt before first tick", cnt_o, 0);
        chk("R2", "tick", tick_o, 1);
        cyc(1);
        chk("R2", "cnt first step", cnt_o, 1);
        cyc(3);
        chk("R5", "cnt at top", cnt_o, 4);
        chk("R5", "evt at top", upd_evt_o, 0);
        cyc(1);
        chk("R8", "immediate reload wrap cnt", cnt_o, 0);
        chk("R5", "evt at wrap", upd_evt_o, 1);
        chk("R5", "flag at wrap", upd_flag_o, 1);
        cyc(1);
        chk("R12", "flag sticky", upd_flag_o, 1);
        chk("R5", "evt single cycle", upd_evt_o, 0);
        chk("R5", "cnt after wrap", cnt_o, 1);
    endtask

    task automatic t_prescale();
        do_reset();
        psc_wr_en = 1; psc_wr_val = 2; arr_wr_en = 1; arr_wr_val = 100;
        cyc(1); psc_wr_en = 0; arr_wr_en = 0; sw_upd = 1;
        cyc(1); sw_upd = 0; cfg_run = 1;
        cyc(3);
        chk("R3", "cnt before divided tick", cnt_o, 0);
        chk("R3", "tick", tick_o, 1);
        cyc(1);
        chk("R3", "cnt first", cnt_o, 1);
        chk("R3", "tick low", tick_o, 0);
        cyc(2);
        chk("R3", "cnt held", cnt_o, 1);
        cyc(1);
        chk("R3", "cnt second", cnt_o, 2);
        psc_wr_en = 1; psc_wr_val = 0;
        cyc(1); psc_wr_en = 0;
        cyc(1);
        chk("R4", "new prescale not yet used", cnt_o, 2);
        cyc(1);
        chk("R4", "old divisor still active", cnt_o, 3);
        sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R10", "sw update clears cnt", cnt_o, 0);
        chk("R4", "phase cleared tick", tick_o, 1);
        cyc(1);
        chk("R4", "new prescale step 1", cnt_o, 1);
        cyc(1);
        chk("R4", "new prescale step 2", cnt_o, 2);
    endtask

    task automatic t_down();
        do_reset();
        cfg_down = 1; arr_wr_en = 1; arr_wr_val = 3;
        cyc(1); arr_wr_en = 0; sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R10", "down sw update loads reload", cnt_o, 3);
        chk("R10", "evt", upd_evt_o, 1);
        chk("R6", "dir follows down", dir_down_o, 1);
        flag_clr = 1; cfg_run = 1;
        cyc(1); flag_clr = 0;
        chk("R12", "flag cleared", upd_flag_o, 0);
        cyc(1);
        chk("R6", "down step", cnt_o, 2);
        cyc(2);
        chk("R6", "down zero", cnt_o, 0);
        chk("R6", "no evt at zero", upd_evt_o, 0);
        cyc(1);
        chk("R6", "underflow reload", cnt_o, 3);
        chk("R6", "underflow evt", upd_evt_o, 1);
        chk("R6", "underflow flag", upd_flag_o, 1);
    endtask

    task automatic t_center();
        do_reset();
        cfg_center = 1; arr_wr_en = 1; arr_wr_val = 3; cfg_run = 1;
        cyc(1); arr_wr_en = 0;
        cyc(3);
        chk("R7", "top", cnt_o, 3);
        chk("R7", "dir up at top", dir_down_o, 0);
        chk("R7", "no evt yet", upd_evt_o, 0);
        cyc(1);
        chk("R7", "after top", cnt_o, 2);
        chk("R7", "dir down", dir_down_o, 1);
        chk("R7", "top evt", upd_evt_o, 1);
        cyc(2);
        chk("R7", "bottom", cnt_o, 0);
        chk("R7", "no evt bottom reach", upd_evt_o, 0);
        cyc(1);
        chk("R7", "after bottom", cnt_o, 1);
        chk("R7", "dir up again", dir_down_o, 0);
        chk("R7", "bottom evt", upd_evt_o, 1);
    endtask

    task automatic t_center_write();
        do_reset();
        cfg_center = 1; arr_wr_en = 1; arr_wr_val = 5;
        cyc(1); arr_wr_en = 0;
        cnt_wr_en = 1; cnt_wr_val = 5;
        cyc(1); cnt_wr_en = 0;
        chk("R13", "write reload cnt", cnt_o, 5);
        chk("R13", "write reload dir", dir_down_o, 1);
        chk("R13", "no evt", upd_evt_o, 0);
        cnt_wr_en = 1; cnt_wr_val = 9;
        cyc(1); cnt_wr_en = 0;
        chk("R13", "above reload keeps down", dir_down_o, 1);
        cnt_wr_en = 1; cnt_wr_val = 0;
        cyc(1); cnt_wr_en = 0;
        chk("R13", "write zero dir", dir_down_o, 0);
        chk("R13", "no evt on zero", upd_evt_o, 0);
        cnt_wr_en = 1; cnt_wr_val = 7;
        cyc(1); cnt_wr_en = 0;
        chk("R13", "above reload keeps up", dir_down_o, 0);
        chk("R13", "cnt written", cnt_o, 7);
    endtask

    task automatic t_buffered_reload();
        do_reset();
        cfg_arr_buffered = 1; arr_wr_en = 1; arr_wr_val = 2; cfg_run = 1;
        cyc(1); arr_wr_en = 0;
        cyc(3);
        chk("R8", "buffered reload not active", cnt_o, 3);
        sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R8", "sw update cnt", cnt_o, 0);
        cyc(2);
        chk("R8", "at new top", cnt_o, 2);
        cyc(1);
        chk("R8", "wrap at new reload", cnt_o, 0);
        chk("R8", "wrap evt", upd_evt_o, 1);
    endtask

    task automatic t_block();
        do_reset();
        arr_wr_en = 1; arr_wr_val = 2; psc_wr_en = 1; psc_wr_val = 1;
        cfg_upd_block = 1; cfg_run = 1;
        cyc(1); arr_wr_en = 0; psc_wr_en = 0;
        cyc(3);
        chk("R9", "wrap still happens", cnt_o, 0);
        chk("R9", "no evt", upd_evt_o, 0);
        chk("R9", "no flag", upd_flag_o, 0);
        cyc(1);
        chk("R9", "prescale shadow unchanged", cnt_o, 1);
        sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R9", "sw clears cnt while blocked", cnt_o, 0);
        chk("R9", "no evt on sw", upd_evt_o, 0);
        chk("R9", "no flag on sw", upd_flag_o, 0);
        cfg_upd_block = 0;
        cyc(1);
        chk("R9", "prescale still old", cnt_o, 1);
    endtask

    task automatic t_sw_quiet();
        do_reset();
        arr_wr_en = 1; arr_wr_val = 100; cfg_run = 1;
        cyc(1); arr_wr_en = 0;
        cyc(3);
        chk("R10", "running cnt", cnt_o, 3);
        sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R10", "cleared", cnt_o, 0);
        chk("R10", "evt", upd_evt_o, 1);
        chk("R10", "flag", upd_flag_o, 1);
        flag_clr = 1;
        cyc(1); flag_clr = 0;
        chk("R12", "flag cleared", upd_flag_o, 0);
        cfg_sw_quiet = 1; sw_upd = 1;
        cyc(1); sw_upd = 0;
        chk("R11", "quiet evt", upd_evt_o, 1);
        chk("R11", "quiet flag", upd_flag_o, 0);
        chk("R11", "quiet cnt", cnt_o, 0);
    endtask

    task automatic t_flag_race();
        do_reset();
        arr_wr_en = 1; arr_wr_val = 1; cfg_run = 1;
        cyc(1); arr_wr_en = 0;
        cyc(1);
        chk("R12", "cnt before wrap", cnt_o, 1);
        flag_clr = 1;
        cyc(1);
        chk("R12", "set beats clear", upd_flag_o, 1);
        chk("R12", "evt", upd_evt_o, 1);
        cyc(1); flag_clr = 0;
        chk("R12", "clear applied", upd_flag_o, 0);
        cyc(1);
        chk("R12", "set again", upd_flag_o, 1);
    endtask

    initial begin
        t_reset();
        t_up_wrap();
        t_prescale();
        t_down();
        t_center();
        t_center_write();
        t_buffered_reload();
        t_block();
        t_sw_quiet();
        t_flag_race();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule